// File: doc/BRIEF.md
# Full-Map Directory Coherence Home Controller

This block is the home node of a small shared-memory system. For every memory block it owns, it stores a presence vector with one bit per processor and a single private bit. The private bit marks a block held by exactly one cache, possibly modified. It also stores the block's memory data.

Caches send it three kinds of request: read miss, write miss and write hit. A write hit asks to become the sole owner of a block the cache already shares. The controller looks up the block's entry. It then either replies at once or sends fetch or invalidate commands to the caches involved. It counts their responses, writes any returned dirty data into memory, replies to the requester and commits the new entry.

The controller works on one transaction at a time. It holds new requests off with ready low until the reply has been taken.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry has an empty presence vector and a clear private bit. Memory word `i` holds the value `i`. reqReady is high and cmdValid and rplValid are low.
- R2: A read miss (reqType 0) to a block with no private copy elsewhere produces no command. The reply is rplType 0 with the memory data to the requester, visible two cycles after the request is accepted. The requester is then added as a sharer.
- R3: A read miss to a block held privately by another processor sends exactly one command, a fetch (cmdType 1), to that owner. The owner's returned data is written to memory and returned in a type 0 reply.
- R4: A write miss (reqType 1) sends an invalidate (cmdType 0) to every present processor except the requester, one per handshake, lowest index first. It then replies rplType 1 with the memory data.
- R5: A write hit (reqType 2) from a processor whose presence bit is set invalidates the other sharers in the same way as R4. It then replies rplType 2, the privacy acknowledgement.
- R6: A write hit from a processor whose presence bit is clear is served as a write miss. The reply is rplType 1 with data.
- R7: After any write completes, only the writer's presence bit is set and the private bit is set. After a read that fetched from an owner, the private bit is clear and both the owner and the reader are sharers.
- R8: The reply is issued only once the number of responses received equals the number of commands sent. That number is the count of the targets, excluding the requester.
- R9: A response flagged dirty (rspDirty high) overwrites the block's memory word with rspData before the reply data is read.
- R10: reqReady is low from the cycle after a request is accepted until the reply handshake completes.
- R11: While cmdValid or rplValid is high and not accepted, the output stays valid and its type, destination and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request from a cache is valid |
| reqReady | output | 1 | Controller accepts a request |
| reqType | input | 2 | 0 read miss, 1 write miss, 2 write hit |
| reqSrc | input | SRC_W | Requesting processor index |
| reqAddr | input | ADDR_W | Block index |
| cmdValid | output | 1 | Command to a cache is valid |
| cmdReady | input | 1 | Network accepts the command |
| cmdType | output | 1 | 0 invalidate, 1 fetch |
| cmdDst | output | SRC_W | Target processor |
| cmdAddr | output | ADDR_W | Block index of the command |
| rspValid | input | 1 | Response from a commanded cache |
| rspReady | output | 1 | Controller accepts a response |
| rspDirty | input | 1 | Response carries modified block data |
| rspData | input | DATA_W | Returned block data |
| rplValid | output | 1 | Reply to the requester is valid |
| rplReady | input | 1 | Requester accepts the reply |
| rplType | output | 2 | 0 shared data, 1 exclusive data, 2 privacy ack |
| rplDst | output | SRC_W | Requester index |
| rplAddr | output | ADDR_W | Block index of the reply |
| rplData | output | DATA_W | Block data |

## Verification
Inputs are driven and outputs sampled on the falling edge. A request driven on one falling edge is taken on the next rising edge. When no command is needed, the reply must be present at the second falling edge after that. The bench checks this exact latency whenever it does not stall the reply channel.

When commands are needed, the first command appears at that same second falling edge. Commands then follow one per accepted handshake. The bench answers each command no earlier than the falling edge after its handshake. It requires that the reply arrives only after every answer it sent, so the reply cannot be earlier than the last acknowledgement plus two edges. Random stalls on the command and reply channels check that the outputs hold while not accepted.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    REQ_READ_MISS  = 2'd0,
    REQ_WRITE_MISS = 2'd1,
    REQ_WRITE_HIT  = 2'd2
  } reqKind_e;

  typedef enum logic {
    CMD_INVAL = 1'b0,
    CMD_FETCH = 1'b1
  } cmdKind_e;

  typedef enum logic [1:0] {
    RPL_SHARED   = 2'd0,
    RPL_EXCL     = 2'd1,
    RPL_PRIV_ACK = 2'd2
  } rplKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadFetch;
    logic loadInval;
    logic takeCmd;
    logic takeRsp;
    logic commit;
  } dirStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isRead;
    logic needFetch;
    logic noTargets;
    logic pendAny;
    logic ackZero;
  } dirFlags_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int SRC_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int CNT_W  = $clog2(NUM_PROC + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        stb,
  output dirFlags_t         flg,
  input  logic [1:0]        reqType,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              rspDirty,
  input  logic [DATA_W-1:0] rspData,
  output logic              cmdType,
  output logic [SRC_W-1:0]  cmdDst,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        rplType,
  output logic [SRC_W-1:0]  rplDst,
  output logic [ADDR_W-1:0] rplAddr,
  output logic [DATA_W-1:0] rplData
);

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_PROC-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_PROC; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [SRC_W-1:0] lowestSet(input logic [NUM_PROC-1:0] v);
    logic [SRC_W-1:0] idx;
    idx = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--) if (v[i]) idx = SRC_W'(i);
    return idx;
  endfunction

  // latched transaction
  logic [1:0]          kindQ;
  logic [SRC_W-1:0]    srcQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [NUM_PROC-1:0] pendQ;
  logic [CNT_W-1:0]    ackCntQ;
  logic                fetchQ;

  // per-block entry views
  logic [NUM_BLOCKS-1:0][NUM_PROC-1:0] presAll;
  logic [NUM_BLOCKS-1:0]               privAll;
  logic [NUM_BLOCKS-1:0][DATA_W-1:0]   memAll;

  logic [NUM_PROC-1:0] curPres;
  logic [NUM_PROC-1:0] reqBit;
  logic [NUM_PROC-1:0] others;
  logic                curPriv;
  logic                isRead;
  logic [SRC_W-1:0]    nextDst;

  always_comb begin
    curPres = presAll[addrQ];
    curPriv = privAll[addrQ];
    reqBit  = NUM_PROC'(1) << srcQ;
    others  = curPres & ~reqBit;
    isRead  = (kindQ == REQ_READ_MISS);
    nextDst = lowestSet(pendQ);
  end

  assign flg.isRead    = isRead;
  assign flg.needFetch = isRead && curPriv && !curPres[srcQ];
  assign flg.noTargets = (others == '0);
  assign flg.pendAny   = (pendQ != '0);
  assign flg.ackZero   = (ackCntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= '0;
      srcQ    <= '0;
      addrQ   <= '0;
      pendQ   <= '0;
      ackCntQ <= '0;
      fetchQ  <= 1'b0;
    end else begin
      if (stb.latchReq) begin
        kindQ  <= reqType;
        srcQ   <= reqSrc;
        addrQ  <= reqAddr;
        fetchQ <= 1'b0;
      end
      if (stb.loadFetch) begin
        pendQ   <= curPres;
        ackCntQ <= CNT_W'(1);
        fetchQ  <= 1'b1;
      end else if (stb.loadInval) begin
        pendQ   <= others;
        ackCntQ <= popCount(others);
        fetchQ  <= 1'b0;
      end else begin
        if (stb.takeCmd) pendQ <= pendQ & ~(NUM_PROC'(1) << nextDst);
        if (stb.takeRsp && ackCntQ != '0) ackCntQ <= ackCntQ - CNT_W'(1);
      end
    end
  end

  // one register set per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : gEntry
    logic [NUM_PROC-1:0] presR;
    logic                privR;
    logic [DATA_W-1:0]   memR;
    logic                hitB;
    assign hitB = (addrQ == ADDR_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        presR <= '0;
        privR <= 1'b0;
        memR  <= DATA_W'(b);
      end else begin
        if (stb.commit && hitB) begin
          if (isRead) begin
            presR <= presR | reqBit;
            if (fetchQ) privR <= 1'b0;
          end else begin
            presR <= reqBit;
            privR <= 1'b1;
          end
        end
        if (stb.takeRsp && rspDirty && hitB) memR <= rspData;
      end
    end

    assign presAll[b] = presR;
    assign privAll[b] = privR;
    assign memAll[b]  = memR;
  end

  always_comb begin
    cmdType = fetchQ ? CMD_FETCH : CMD_INVAL;
    cmdDst  = nextDst;
    cmdAddr = addrQ;
    rplDst  = srcQ;
    rplAddr = addrQ;
    rplData = memAll[addrQ];
    if (isRead)                                            rplType = RPL_SHARED;
    else if (kindQ == REQ_WRITE_HIT && curPres[srcQ])      rplType = RPL_PRIV_ACK;
    else                                                   rplType = RPL_EXCL;
  end

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dirFlags_t  flg,
  output dirStrobe_t stb,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       cmdValid,
  input  logic       cmdReady,
  input  logic       rspValid,
  output logic       rspReady,
  output logic       rplValid,
  input  logic       rplReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_COLLECT, ST_REPLY} ctlState_e;
  ctlState_e stateQ, stateD;

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    reqReady = 1'b0;
    cmdValid = 1'b0;
    rspReady = 1'b0;
    rplValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateD       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (flg.isRead) begin
          if (flg.needFetch) begin
            stb.loadFetch = 1'b1;
            stateD        = ST_COLLECT;
          end else begin
            stateD = ST_REPLY;
          end
        end else begin
          stb.loadInval = 1'b1;
          stateD        = flg.noTargets ? ST_REPLY : ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        cmdValid    = flg.pendAny;
        stb.takeCmd = flg.pendAny && cmdReady;
        rspReady    = 1'b1;
        stb.takeRsp = rspValid;
        if (!flg.pendAny && flg.ackZero) stateD = ST_REPLY;
      end
      ST_REPLY: begin
        rplValid = 1'b1;
        if (rplReady) begin
          stb.commit = 1'b1;
          stateD     = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int SRC_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqType,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic              cmdType,
  output logic [SRC_W-1:0]  cmdDst,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic              rspDirty,
  input  logic [DATA_W-1:0] rspData,
  output logic              rplValid,
  input  logic              rplReady,
  output logic [1:0]        rplType,
  output logic [SRC_W-1:0]  rplDst,
  output logic [ADDR_W-1:0] rplAddr,
  output logic [DATA_W-1:0] rplData
);

  dirStrobe_t stb;
  dirFlags_t  flg;

  dir_control uCtl (
    .clk(clk), .rstN(rstN), .flg(flg), .stb(stb),
    .reqValid(reqValid), .reqReady(reqReady),
    .cmdValid(cmdValid), .cmdReady(cmdReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .rplValid(rplValid), .rplReady(rplReady)
  );

  dir_datapath #(.NUM_PROC(NUM_PROC), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .flg(flg),
    .reqType(reqType), .reqSrc(reqSrc), .reqAddr(reqAddr),
    .rspDirty(rspDirty), .rspData(rspData),
    .cmdType(cmdType), .cmdDst(cmdDst), .cmdAddr(cmdAddr),
    .rplType(rplType), .rplDst(rplDst), .rplAddr(rplAddr), .rplData(rplData)
  );

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int SRC_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [SRC_W-1:0]  reqSrc,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              cmdType,
  input logic [SRC_W-1:0]  cmdDst,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rplValid,
  input logic              rplReady,
  input logic [1:0]        rplType,
  input logic [SRC_W-1:0]  rplDst,
  input logic [DATA_W-1:0] rplData
);

  logic [SRC_W-1:0] srcSeen;
  logic [7:0]       sentCnt;
  logic [7:0]       ackCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSeen <= '0;
      sentCnt <= '0;
      ackCnt  <= '0;
    end else if (reqValid && reqReady) begin
      srcSeen <= reqSrc;
      sentCnt <= '0;
      ackCnt  <= '0;
    end else begin
      if (cmdValid && cmdReady) sentCnt <= sentCnt + 8'd1;
      if (rspValid && rspReady) ackCnt  <= ackCnt + 8'd1;
    end
  end

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_busy_during_reply_R10: assert property (@(posedge clk) disable iff (!rstN)
    rplValid |-> !reqReady);

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdDst) && $stable(cmdType)));

  assert_rpl_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rplValid && !rplReady) |=> (rplValid && $stable(rplType) && $stable(rplDst) && $stable(rplData)));

  assert_no_self_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == 1'b0) |-> (cmdDst != srcSeen));

  assert_acks_complete_R8: assert property (@(posedge clk) disable iff (!rstN)
    rplValid |-> (sentCnt == ackCnt));

  assert_reply_to_requester_R2: assert property (@(posedge clk) disable iff (!rstN)
    rplValid |-> (rplDst == srcSeen));

  assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdType == 1'b1) |-> (sentCnt == 8'd0));

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
  .NUM_PROC(NUM_PROC), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqSrc(reqSrc),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdType(cmdType), .cmdDst(cmdDst),
  .rspValid(rspValid), .rspReady(rspReady),
  .rplValid(rplValid), .rplReady(rplReady), .rplType(rplType), .rplDst(rplDst),
  .rplData(rplData)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int SW = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic          reqValid = 1'b0, reqReady;
  logic [1:0]    reqType = '0;
  logic [SW-1:0] reqSrc = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          cmdValid, cmdReady = 1'b1, cmdType;
  logic [SW-1:0] cmdDst;
  logic [AW-1:0] cmdAddr;
  logic          rspValid = 1'b0, rspReady, rspDirty = 1'b0;
  logic [DW-1:0] rspData = '0;
  logic          rplValid, rplReady = 1'b1;
  logic [1:0]    rplType;
  logic [SW-1:0] rplDst;
  logic [AW-1:0] rplAddr;
  logic [DW-1:0] rplData;

  dir_home_ctrl #(.NUM_PROC(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqType(reqType), .reqSrc(reqSrc), .reqAddr(reqAddr),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdType(cmdType), .cmdDst(cmdDst), .cmdAddr(cmdAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspDirty(rspDirty), .rspData(rspData),
    .rplValid(rplValid), .rplReady(rplReady), .rplType(rplType), .rplDst(rplDst),
    .rplAddr(rplAddr), .rplData(rplData)
  );

  int checks = 0;
  int errors = 0;

  // reference model of the directory
  logic [NP-1:0] mPres [NB];
  logic          mPriv [NB];
  logic [DW-1:0] mMem  [NB];
  logic [DW-1:0] ownVal [NB];

  // results of the last transaction for directed checks
  int            lastCmdCount;
  int            lastCmdDst;
  logic [DW-1:0] lastRplData;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input int kind, input int src, input int addr, input bit stall);
    logic [NP-1:0] prePres;
    logic          prePriv;
    logic [NP-1:0] expMask;
    logic [DW-1:0] expData;
    int            expList [NP];
    int            nExp;
    int            expCmd;
    int            expRpl;
    bit            fetch;
    string         tag;
    int            rq [NP];
    int            qHead, qTail;
    int            nGot, acksSent, acksAtRpl, latency;
    bit            seqOk, busyBad, holdBad, done, holdPend;
    int            holdDst;
    logic [1:0]    gotType;
    logic [DW-1:0] gotData;
    logic [SW-1:0] gotDst;
    logic [AW-1:0] gotAddr;

    prePres = mPres[addr];
    prePriv = mPriv[addr];
    fetch   = 1'b0;
    if (kind == 0) begin
      fetch   = prePriv && !prePres[src];
      expMask = fetch ? prePres : '0;
      expCmd  = 1;
      expRpl  = 0;
      tag     = fetch ? "R3" : "R2";
    end else begin
      expMask = prePres & ~(NP'(1) << src);
      expCmd  = 0;
      expRpl  = (kind == 2 && prePres[src]) ? 2 : 1;
      tag     = (kind == 1) ? "R4" : (prePres[src] ? "R5" : "R6");
    end
    nExp = 0;
    for (int i = 0; i < NP; i++) if (expMask[i]) begin expList[nExp] = i; nExp++; end
    expData = mMem[addr];
    if (prePriv && expMask != '0) expData = ownVal[addr];

    qHead = 0; qTail = 0; nGot = 0; acksSent = 0; acksAtRpl = -1; latency = 0;
    seqOk = 1'b1; busyBad = 1'b0; holdBad = 1'b0; done = 1'b0; holdPend = 1'b0; holdDst = 0;
    gotType = '0; gotData = '0; gotDst = '0; gotAddr = '0;

    @(negedge clk);
    rspValid = 1'b0;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqType  = 2'(kind);
    reqSrc   = SW'(src);
    reqAddr  = AW'(addr);

    for (int cyc = 1; cyc <= 200 && !done; cyc++) begin
      @(negedge clk);
      if (cyc == 1) reqValid = 1'b0;
      if (reqReady) busyBad = 1'b1;
      // R11: a command left waiting must still be there unchanged
      if (holdPend && (!cmdValid || int'(cmdDst) != holdDst)) holdBad = 1'b1;
      holdPend = 1'b0;
      // answer one queued command
      rspValid = 1'b0;
      rspDirty = 1'b0;
      if (qHead != qTail && rspReady && (!stall || ($urandom % 2) == 0)) begin
        rspValid = 1'b1;
        rspDirty = prePriv && prePres[rq[qHead]];
        rspData  = ownVal[addr];
        qHead++;
        acksSent++;
      end
      cmdReady = stall ? (($urandom % 2) == 0) : 1'b1;
      if (cmdValid && cmdReady) begin
        if (nGot >= nExp || int'(cmdDst) != expList[nGot] || int'(cmdType) != expCmd
            || int'(cmdAddr) != addr) seqOk = 1'b0;
        if (qTail < NP) begin rq[qTail] = int'(cmdDst); qTail++; end
        lastCmdDst = int'(cmdDst);
        nGot++;
      end else if (cmdValid) begin
        holdPend = 1'b1;
        holdDst  = int'(cmdDst);
      end
      rplReady = stall ? (($urandom % 2) == 0) : 1'b1;
      if (rplValid && rplReady) begin
        gotType   = rplType;
        gotData   = rplData;
        gotDst    = rplDst;
        gotAddr   = rplAddr;
        acksAtRpl = acksSent;
        latency   = cyc;
        done      = 1'b1;
      end
    end

    check(done, "R8", "reply arrived", longint'(done), 1);
    check(seqOk && nGot == nExp, tag, "command sequence count", nGot, nExp);
    check(gotType == 2'(expRpl), tag, "reply type", gotType, expRpl);
    if (expRpl != 2) check(gotData == expData, tag, "reply data", gotData, expData);
    check(int'(gotDst) == src && int'(gotAddr) == addr, "R2", "reply dst/addr",
          {gotDst, gotAddr}, {SW'(src), AW'(addr)});
    check(!busyBad, "R10", "reqReady low while busy", longint'(busyBad), 0);
    check(acksAtRpl == nExp, "R8", "acks before reply", acksAtRpl, nExp);
    if (stall) check(!holdBad, "R11", "command held while stalled", longint'(holdBad), 0);
    if (!stall && nExp == 0) check(latency == 2, "R2", "reply latency", latency, 2);

    lastCmdCount = nGot;
    lastRplData  = gotData;

    // model update per R2..R9
    mMem[addr] = expData;
    if (kind == 0) begin
      mPres[addr] = prePres | (NP'(1) << src);
      if (fetch) mPriv[addr] = 1'b0;
    end else begin
      mPres[addr]  = NP'(1) << src;
      mPriv[addr]  = 1'b1;
      ownVal[addr] = DW'($urandom);
    end
    reqValid = 1'b0;
    cmdReady = 1'b1;
    rplReady = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] saved;
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin
      mPres[b] = '0; mPriv[b] = 1'b0; mMem[b] = DW'(b); ownVal[b] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check(cmdValid == 1'b0 && rplValid == 1'b0, "R1", "no valid outputs after reset",
          {cmdValid, rplValid}, 0);

    // R1 and R2: clean reads return the block index
    runTxn(0, 0, 1, 1'b0);
    check(lastRplData == 16'd1, "R1", "initial memory word 1", lastRplData, 1);
    runTxn(0, 1, 5, 1'b0);
    check(lastRplData == 16'd5, "R1", "initial memory word 5", lastRplData, 5);
    runTxn(0, 2, 1, 1'b0);
    // R5: sharer P0 upgrades, P2 invalidated
    runTxn(2, 0, 1, 1'b0);
    // R7: only P0 present and private, so a read by P3 fetches from P0
    saved = ownVal[1];
    runTxn(0, 3, 1, 1'b0);
    check(lastCmdCount == 1 && lastCmdDst == 0, "R7", "fetch goes only to writer",
          lastCmdDst, 0);
    check(lastRplData == saved, "R3", "fetched owner data", lastRplData, saved);
    // R4: write miss by P1 invalidates P0 and P3 in ascending order
    runTxn(1, 1, 1, 1'b0);
    check(lastCmdCount == 2, "R4", "invalidate count", lastCmdCount, 2);
    // R6: write hit from a non-sharer
    runTxn(2, 2, 2, 1'b0);
    check(lastRplData == 16'd2, "R6", "write hit non-sharer gets data", lastRplData, 2);
    // R9: dirty data from invalidated owner reaches memory and the reply
    saved = ownVal[2];
    runTxn(1, 3, 2, 1'b0);
    check(lastRplData == saved, "R9", "dirty ack data in reply", lastRplData, saved);
    runTxn(0, 2, 2, 1'b0);
    // R7: after a fetch the block is clean with both sharers
    runTxn(1, 0, 2, 1'b0);
    check(lastCmdCount == 2, "R7", "both sharers present after fetch", lastCmdCount, 2);

    // random traffic with channel stalls
    for (int t = 0; t < 150; t++) begin
      runTxn(int'($urandom % 3), int'($urandom % NP), int'($urandom % 4), ($urandom % 2) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule